// File: doc/BRIEF.md
# Root Port Status and Reset Controller

This block holds the status and control word of each downstream root port of a host controller. Each word is 16 bits wide and sits behind a simple word-addressed register interface. It follows a device-present input from each port, records every change of it in a sticky flag, and raises an event output while any flag is pending. Software clears a flag by writing 1 to it.

Software owns the reset bit of each port and sets and clears it itself. The block does not time the reset pulse. It does guard the enable bit: enable can be set only after a reset has been released while a device was attached, and only once a settle window of `SETTLE_CYC` clock cycles has passed since that release. A detach, or a new reset, removes the enable and the permission to set it.

Port `p` occupies word address `p`. Reads are combinational on the address.

Top module: `rootport_regs`

## Requirements
- R1: Bit 0 of a port word shows the device-present input as it was sampled at the previous clock edge.
- R2: Any change of a port's device-present input, whether a connect or a detach, sets bit 1 of that port's word at the next clock edge.
- R3: Writing 1 to bit 1 clears that flag. Writing 0 to bit 1 leaves it unchanged. If a new change of the present input and a clearing write arrive at the same edge, the flag stays set.
- R4: Bit 9 (port reset) is plain read/write: it takes the written value on every write to that port.
- R5: A write to bit 2 (enable) sets enable only when both conditions hold: reset was released (bit 9 written 0 while it was 1) with the device present before and at that edge, and at least `SETTLE_CYC` cycles have passed since then. The write must come no earlier than edge t+SETTLE_CYC+1, where t is the release edge. Otherwise the write leaves enable at 0. Writing 0 to bit 2 always clears enable.
- R6: While bit 9 is 1, or on any write that sets bit 9, enable is 0, and the settle permission is withdrawn.
- R7: A detach (bit 0 was 1, present input now 0) clears enable and withdraws the settle permission at that edge. Enable is never 1 while bit 0 is 0.
- R8: The output `evt_o` is 1 exactly when bit 1 of some port word is 1.
- R9: Bits other than 0, 1, 2 and 9 read 0. A read of an address at or above `NUM_PORTS` returns 0, and a write to such an address changes no port.
- R10: After `rst_ni` is asserted, every port word reads 0 and `evt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | ADDR_W | Word address; port p is at address p |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed word, combinational |
| present_i | input | NUM_PORTS | Device-present input, one bit per port |
| evt_o | output | 1 | High while any port's change flag is set |

## Verification
The checker tests on every cycle the properties that hold locally. A change of the present input is followed by a set flag. A flag falls only after a clearing write to its own port. Enable rises only after an enabling write to its own port. Enable is never 1 while reset is set or while the port is detached.

Only the bench scenarios can show the timing of the settle window. They check that an enable write is refused one cycle before the window ends and accepted once it has ended. The same applies to a release with no device attached granting no permission, and to a new reset or a detach withdrawing the permission. Those checks run against a reference model driven by random and directed traffic.

// File: rtl/rootport_pkg.sv
package rootport_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned B_CONN  = 0;
  localparam int unsigned B_CHG   = 1;
  localparam int unsigned B_EN    = 2;
  localparam int unsigned B_PRST  = 9;
endpackage

// File: rtl/rootport_settle.sv
module rootport_settle #(
  parameter int unsigned SETTLE_CYC = 64,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  output logic ready_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= CNT_W'(SETTLE_CYC);
    end else if (armed_q && cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign ready_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/rootport_port.sv
module rootport_port
  import rootport_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              present_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] reg_o,
  output logic              chg_o
);
  logic conn_q, chg_q, en_q, prst_q;
  logic conn_evt, detach, prst_wr, prst_rel, ready;

  assign conn_evt = present_i ^ conn_q;
  assign detach   = conn_q & ~present_i;
  assign prst_wr  = we_i & wdata_i[B_PRST];
  assign prst_rel = we_i & ~wdata_i[B_PRST] & prst_q;

  rootport_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (detach | prst_wr),
    .start_i (prst_rel & conn_q & present_i),
    .ready_o (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      chg_q  <= 1'b0;
      en_q   <= 1'b0;
      prst_q <= 1'b0;
    end else begin
      conn_q <= present_i;
      // new event wins over a clearing write
      if (conn_evt)                        chg_q <= 1'b1;
      else if (we_i && wdata_i[B_CHG])     chg_q <= 1'b0;
      if (we_i)                            prst_q <= wdata_i[B_PRST];
      if (detach || prst_q || prst_wr)     en_q <= 1'b0;
      else if (we_i)                       en_q <= wdata_i[B_EN] & ready;
    end
  end

  always_comb begin
    reg_o         = '0;
    reg_o[B_CONN] = conn_q;
    reg_o[B_CHG]  = chg_q;
    reg_o[B_EN]   = en_q;
    reg_o[B_PRST] = prst_q;
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/rootport_regs.sv
module rootport_regs
  import rootport_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 2,
  parameter int unsigned SETTLE_CYC = 64,
  localparam int unsigned ADDR_W = $clog2(NUM_PORTS) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  input  logic [NUM_PORTS-1:0] present_i,
  output logic                 evt_o
);
  logic [WORD_W-1:0]    port_regs [NUM_PORTS];
  logic [NUM_PORTS-1:0] chg;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rootport_port #(.SETTLE_CYC(SETTLE_CYC)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .present_i (present_i[p]),
      .we_i      (we_i && (addr_i == ADDR_W'(p))),
      .wdata_i   (wdata_i),
      .reg_o     (port_regs[p]),
      .chg_o     (chg[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr_i == ADDR_W'(p)) rdata_o = port_regs[p];
  end

  assign evt_o = |chg;
endmodule

// File: rtl/rootport_checker.sv
module rootport_checker
  import rootport_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned ADDR_W = $clog2(NUM_PORTS) + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [WORD_W-1:0]    wdata_i,
  input logic [NUM_PORTS-1:0] present_i,
  input logic [WORD_W-1:0]    port_regs [NUM_PORTS]
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_CHANGE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (present_i[p] != port_regs[p][B_CONN]) |=> port_regs[p][B_CHG]); // R2
    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(port_regs[p][B_CHG]) |->
        $past(we_i && addr_i == ADDR_W'(p) && wdata_i[B_CHG])); // R3
    AST_EN_RISE_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(port_regs[p][B_EN]) |->
        $past(we_i && addr_i == ADDR_W'(p) && wdata_i[B_EN])); // R5
    AST_NO_EN_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_regs[p][B_PRST] |-> !port_regs[p][B_EN]); // R6
    AST_NO_EN_DETACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_regs[p][B_CONN] |-> !port_regs[p][B_EN]); // R7
  end
endmodule

bind rootport_regs rootport_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/sim_rootport_regs.sv
`timescale 1ns/100ps
module sim_rootport_regs;
  localparam int NP = 2;
  localparam int SC = 64;
  localparam int AW = $clog2(NP) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NP-1:0] present = '0;
  logic          evt;

  int checks = 0, fails = 0;

  // reference model state
  bit m_conn [NP], m_chg [NP], m_en [NP], m_rst [NP], m_arm [NP];
  int m_cnt [NP];

  always #4 clk = ~clk;

  rootport_regs #(.NUM_PORTS(NP), .SETTLE_CYC(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .present_i(present), .evt_o(evt));

  function automatic void model_step();
    for (int p = 0; p < NP; p++) begin
      bit w   = we && (int'(addr) == p);
      bit det = m_conn[p] && !present[p];
      bit rel = w && !wdata[9] && m_rst[p];
      bit rdy = m_arm[p] && (m_cnt[p] == 0);
      if (det || m_rst[p] || (w && wdata[9])) m_en[p] = 0;
      else if (w) m_en[p] = wdata[2] && rdy;
      if (det || (w && wdata[9])) begin m_arm[p] = 0; m_cnt[p] = 0; end
      else if (rel && m_conn[p] && present[p]) begin m_arm[p] = 1; m_cnt[p] = SC; end
      else if (m_arm[p] && m_cnt[p] != 0) m_cnt[p]--;
      if (present[p] != m_conn[p]) m_chg[p] = 1;
      else if (w && wdata[1]) m_chg[p] = 0;
      if (w) m_rst[p] = wdata[9];
      m_conn[p] = present[p];
    end
  endfunction

  function automatic logic [15:0] model_word(int p);
    logic [15:0] v = '0;
    if (p >= NP) return v;
    v[0] = m_conn[p]; v[1] = m_chg[p]; v[2] = m_en[p]; v[9] = m_rst[p];
    return v;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // sample all words at the negedge, with no write in flight
  task automatic check_all();
    logic any = 0;
    we = 1'b0;
    for (int p = 0; p < (1 << AW); p++) begin
      logic [15:0] e = model_word(p);
      addr = AW'(p);
      #0.4;
      chk("R1 conn", {15'b0, rdata[0]}, {15'b0, e[0]});
      chk("R3 chg", {15'b0, rdata[1]}, {15'b0, e[1]});
      if (p < NP && m_rst[p]) chk("R6 en", {15'b0, rdata[2]}, {15'b0, e[2]});
      else if (p < NP && !m_conn[p]) chk("R7 en", {15'b0, rdata[2]}, {15'b0, e[2]});
      else chk("R5 en", {15'b0, rdata[2]}, {15'b0, e[2]});
      chk("R4 prst", {15'b0, rdata[9]}, {15'b0, e[9]});
      chk("R9 other", rdata & 16'hFDF8, 16'h0);
      any |= e[1];
    end
    chk("R8 evt", {15'b0, evt}, {15'b0, any});
  endtask

  task automatic cyc(bit w, int a, logic [15:0] d, logic [NP-1:0] pr);
    we = w; addr = AW'(a); wdata = d; present = pr;
    model_step();
    @(posedge clk); @(negedge clk);
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, present);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int p = 0; p < NP; p++) begin
      m_conn[p] = 0; m_chg[p] = 0; m_en[p] = 0; m_rst[p] = 0; m_arm[p] = 0; m_cnt[p] = 0;
    end
    repeat (2) @(negedge clk);
    // R10 reset state
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 attach port 0
    cyc(0, 0, 16'h0, 2'b01);
    // R3 write 0 to flag keeps it, write 1 clears
    cyc(1, 0, 16'h0000, 2'b01);
    cyc(1, 0, 16'h0002, 2'b01);
    // R5 enable refused without reset
    cyc(1, 0, 16'h0004, 2'b01);
    // R4 R6 reset, enable attempt during reset
    cyc(1, 0, 16'h0200, 2'b01);
    cyc(1, 0, 16'h0204, 2'b01);
    // release, then enable one cycle too early
    cyc(1, 0, 16'h0000, 2'b01);
    idle(SC - 1);
    cyc(1, 0, 16'h0004, 2'b01);
    // R5 accepted after window
    cyc(1, 0, 16'h0004, 2'b01);
    // R7 detach clears enable
    cyc(0, 0, 16'h0, 2'b00);
    cyc(1, 0, 16'h0004, 2'b00);
    // R3 event and clear at same edge: set wins
    cyc(1, 0, 16'h0002, 2'b01);
    // release with no device gives no permission (port 1)
    cyc(1, 1, 16'h0200, 2'b01);
    cyc(1, 1, 16'h0000, 2'b01);
    idle(SC + 2);
    cyc(1, 1, 16'h0004, 2'b01);
    // R9 out-of-range write
    cyc(1, 3, 16'hFFFF, 2'b01);
    // R6 new reset withdraws permission on port 0
    cyc(1, 0, 16'h0200, 2'b01);
    cyc(1, 0, 16'h0000, 2'b01);
    idle(SC);
    cyc(1, 0, 16'h0200, 2'b01);
    cyc(1, 0, 16'h0000, 2'b01);
    cyc(1, 0, 16'h0004, 2'b01);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0] pr = present;
      logic [15:0] d = 16'($urandom);
      if ($urandom_range(0, 15) == 0) pr[$urandom_range(0, NP - 1)] ^= 1'b1;
      if ($urandom_range(0, 3) != 0) d[9] = 1'b0;
      cyc($urandom_range(0, 5) == 0, $urandom_range(0, (1 << AW) - 1), d, pr);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule